// File: doc/BRIEF.md
# Instruction Fetch Request and Stale Response Tracker

This block decides, cycle by cycle, whether the instruction-fetch unit should ask memory for more bytes. It also remembers whether a fetch reference is in flight. A fetch is requested only when the pipeline front end has room for more bytes, the unit is neither paused nor in test mode, no functional reset is active, and no earlier reference is still outstanding. Room exists when a flush (new PC or taken jump) is happening, or when both byte holding stages F and G are empty and no data is arriving.

When the pipeline is flushed while a reference is in flight, the data that later comes back belongs to the old instruction stream. The block raises a kill flag, and that flag masks exactly one returning response. The arrival of that response clears the flag. The qualified strobe that marks stage F valid fires only for responses that are not stale. Data arrivals count only on the even phase of the two-phase fetch cycle.

Top module: `fetch_track`

## Requirements
- R1: `fetchReq` is 1 exactly when `pause`=0, `testMode`=0, `softReset`=0, `refOutstanding`=0 and room exists. Room means `flush`=1, or `fValid`=0 and `gValid`=0 with no effective arrival in that cycle.
- R2: While `pause` or `testMode` is 1, `fetchReq` is 0.
- R3: When `memAck`=1 in a cycle where `fetchReq`=1, `refOutstanding` is 1 from the next cycle on. A `memAck` in a cycle without `fetchReq` is ignored, and `refOutstanding` stays 0.
- R4: An effective arrival clears `refOutstanding` in the following cycle.
- R5: A `dataArrive` pulse is effective only when `phaseEven`=1. With `phaseEven`=0 it gives no `makeFValid` and leaves `refOutstanding` unchanged.
- R6: A `flush` in a cycle where `refOutstanding`=1 and there is no effective arrival sets `killResp` in the next cycle.
- R7: While `killResp`=1, an effective arrival produces no `makeFValid`, and `killResp` is 0 in the following cycle. A later arrival is then delivered normally.
- R8: `makeFValid` is 1 in the same cycle as an effective arrival, provided `killResp`=0 and `flush`=0.
- R9: `softReset`=1 holds `fetchReq` at 0 and clears both `refOutstanding` and `killResp` in the next cycle.
- R10: After the hardware reset (`rstN` low), `refOutstanding`, `killResp` and `makeFValid` are 0.
- R11: When a flush and an effective arrival share a cycle, that arrival is stale: `makeFValid` stays 0, `killResp` is not set, and `refOutstanding` clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low hardware reset |
| softReset | input | 1 | Functional reset of the fetch unit |
| flush | input | 1 | Pipeline flush (new PC or taken jump) |
| pause | input | 1 | Fetch unit paused |
| testMode | input | 1 | Fetch unit in test mode |
| memAck | input | 1 | Memory accepted the current fetch request |
| dataArrive | input | 1 | Fetch data returning from memory |
| fValid | input | 1 | Stage F holds valid bytes |
| gValid | input | 1 | Stage G holds valid bytes |
| phaseEven | input | 1 | High on the even phase of the fetch cycle |
| fetchReq | output | 1 | Request a fetch reference |
| refOutstanding | output | 1 | A reference is in flight |
| killResp | output | 1 | Next returning response is stale |
| makeFValid | output | 1 | Qualified strobe to mark stage F valid |

## Verification
On every cycle, the assertions check the single-reference rule, the pause and test-mode suppression, the blocking of F validation on odd phases and while a kill is pending, and the effect of the strobes on the next state of both flags. The bench's directed scenarios have to show the sequences that need several cycles. These are a kill masking exactly one response and then letting the next one through, a flush colliding with an arrival, an ignored acknowledge, and the room rules on the F and G valid flags.

// File: rtl/fetch_trk_pkg.sv
package fetch_trk_pkg;
  // strobes from control to flag storage
  typedef struct packed {
    logic wipe;     // functional reset: clear both flags
    logic setRef;   // reference accepted by memory
    logic clrRef;   // effective arrival retires the reference
    logic setKill;  // flush while in flight
    logic clrKill;  // arrival consumes the stale response
  } trkStrobe_t;
endpackage

// File: rtl/fetch_trk_state.sv
module fetch_trk_state
  import fetch_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  trkStrobe_t strobe,
  output logic       refOutstanding,
  output logic       killResp
);
  logic refQ, killQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refQ  <= 1'b0;
      killQ <= 1'b0;
    end else begin
      if (strobe.wipe)        refQ <= 1'b0;
      else if (strobe.setRef) refQ <= 1'b1;
      else if (strobe.clrRef) refQ <= 1'b0;

      if (strobe.wipe)         killQ <= 1'b0;
      else if (strobe.clrKill) killQ <= 1'b0;
      else if (strobe.setKill) killQ <= 1'b1;
    end
  end

  assign refOutstanding = refQ;
  assign killResp       = killQ;

  AST_REF_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setRef && !strobe.wipe |=> refOutstanding); // R3
  AST_WIPE_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipe |=> !refOutstanding && !killResp); // R9
  AST_KILL_DROP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrKill |=> !killResp); // R7
endmodule

// File: rtl/fetch_trk_ctrl.sv
module fetch_trk_ctrl
  import fetch_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       softReset,
  input  logic       flush,
  input  logic       pause,
  input  logic       testMode,
  input  logic       memAck,
  input  logic       dataArrive,
  input  logic       fValid,
  input  logic       gValid,
  input  logic       phaseEven,
  input  logic       refOutstanding,
  input  logic       killResp,
  output logic       fetchReq,
  output logic       makeFValid,
  output trkStrobe_t strobe
);
  logic arrivalEff, roomAvail, blocked;

  always_comb begin
    arrivalEff = dataArrive & phaseEven;
    roomAvail  = flush | (~fValid & ~gValid & ~arrivalEff);
    blocked    = pause | testMode | softReset | refOutstanding;
    fetchReq   = roomAvail & ~blocked;
    makeFValid = arrivalEff & ~killResp & ~flush;

    strobe.wipe    = softReset;
    strobe.setRef  = memAck & fetchReq;
    strobe.clrRef  = arrivalEff;
    strobe.setKill = flush & refOutstanding & ~arrivalEff;
    strobe.clrKill = arrivalEff;
  end

  AST_ONE_REF: assert property (@(posedge clk) disable iff (!rstN)
    refOutstanding |-> !fetchReq); // R1
  AST_HALT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (pause || testMode) |-> !fetchReq); // R2
  AST_ODD_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    !phaseEven |-> !makeFValid); // R5
  AST_NO_STALE: assert property (@(posedge clk) disable iff (!rstN)
    killResp |-> !makeFValid); // R7
  AST_FLUSH_HIT: assert property (@(posedge clk) disable iff (!rstN)
    flush && dataArrive && phaseEven |-> !makeFValid); // R11
endmodule

// File: rtl/fetch_track.sv
module fetch_track
  import fetch_trk_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic softReset,
  input  logic flush,
  input  logic pause,
  input  logic testMode,
  input  logic memAck,
  input  logic dataArrive,
  input  logic fValid,
  input  logic gValid,
  input  logic phaseEven,
  output logic fetchReq,
  output logic refOutstanding,
  output logic killResp,
  output logic makeFValid
);
  trkStrobe_t strobe;

  fetch_trk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .softReset(softReset), .flush(flush),
    .pause(pause), .testMode(testMode), .memAck(memAck),
    .dataArrive(dataArrive), .fValid(fValid), .gValid(gValid),
    .phaseEven(phaseEven), .refOutstanding(refOutstanding),
    .killResp(killResp), .fetchReq(fetchReq), .makeFValid(makeFValid),
    .strobe(strobe)
  );

  fetch_trk_state u_state (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .refOutstanding(refOutstanding), .killResp(killResp)
  );

  AST_RST_IDLE: assert property (@(posedge clk)
    !rstN |=> !refOutstanding && !killResp); // R10
endmodule

// File: tb/tb_fetch_track.sv
module tb_fetch_track;
  logic clk = 1'b0;
  logic rstN, softReset, flush, pause, testMode, memAck, dataArrive;
  logic fValid, gValid, phaseEven;
  logic fetchReq, refOutstanding, killResp, makeFValid;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fetch_track dut (
    .clk(clk), .rstN(rstN), .softReset(softReset), .flush(flush),
    .pause(pause), .testMode(testMode), .memAck(memAck),
    .dataArrive(dataArrive), .fValid(fValid), .gValid(gValid),
    .phaseEven(phaseEven), .fetchReq(fetchReq),
    .refOutstanding(refOutstanding), .killResp(killResp),
    .makeFValid(makeFValid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // advance one edge; inputs change 2ns after it, checks at 3ns
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    softReset = 0; flush = 0; pause = 0; testMode = 0; memAck = 0;
    dataArrive = 0; fValid = 0; gValid = 0; phaseEven = 1;
  endtask

  // issue one accepted reference; ends with refOutstanding expected 1
  task automatic launch();
    idle();
    #1 chk("R1 request when empty", fetchReq, 1'b1);
    memAck = 1;
    step();
    memAck = 0;
    #1 chk("R3 outstanding after ack", refOutstanding, 1'b1);
  endtask

  task automatic t_reset();
    idle(); pause = 1; rstN = 0;
    step(); step();
    rstN = 1;
    #1;
    chk("R10 ref after reset", refOutstanding, 1'b0);
    chk("R10 kill after reset", killResp, 1'b0);
    chk("R10 makeF after reset", makeFValid, 1'b0);
    step();
  endtask

  task automatic t_room();
    idle(); fValid = 1;
    #1 chk("R1 F full no room", fetchReq, 1'b0);
    fValid = 0; gValid = 1;
    #1 chk("R1 G full no room", fetchReq, 1'b0);
    flush = 1;
    #1 chk("R1 flush gives room", fetchReq, 1'b1);
    flush = 0; gValid = 0; dataArrive = 1;
    #1 chk("R1 arrival removes room", fetchReq, 1'b0);
    dataArrive = 0;
    #1 chk("R1 empty gives room", fetchReq, 1'b1);
    pause = 1;
    #1 chk("R2 pause blocks", fetchReq, 1'b0);
    pause = 0; testMode = 1;
    #1 chk("R2 test blocks", fetchReq, 1'b0);
    testMode = 0;
    step();
  endtask

  task automatic t_normal();
    idle(); pause = 1; memAck = 1;
    step();
    memAck = 0;
    #1 chk("R3 stray ack ignored", refOutstanding, 1'b0);
    launch();
    chk("R1 single reference", fetchReq, 1'b0);
    phaseEven = 0; dataArrive = 1;
    #1 chk("R5 odd phase no makeF", makeFValid, 1'b0);
    step();
    dataArrive = 0; phaseEven = 1;
    #1 chk("R5 odd phase keeps ref", refOutstanding, 1'b1);
    dataArrive = 1;
    #1 chk("R8 arrival makes F valid", makeFValid, 1'b1);
    step();
    dataArrive = 0;
    #1 chk("R4 arrival clears ref", refOutstanding, 1'b0);
  endtask

  task automatic t_kill();
    launch();
    flush = 1;
    step();
    flush = 0;
    #1 chk("R6 flush sets kill", killResp, 1'b1);
    dataArrive = 1;
    #1 chk("R7 stale masked", makeFValid, 1'b0);
    step();
    dataArrive = 0;
    #1 chk("R7 kill cleared by arrival", killResp, 1'b0);
    chk("R4 stale arrival clears ref", refOutstanding, 1'b0);
    launch();
    dataArrive = 1;
    #1 chk("R7 next response delivered", makeFValid, 1'b1);
    step();
    dataArrive = 0;
  endtask

  task automatic t_collide();
    launch();
    flush = 1; dataArrive = 1;
    #1 chk("R11 collision no makeF", makeFValid, 1'b0);
    step();
    flush = 0; dataArrive = 0;
    #1 chk("R11 collision no kill", killResp, 1'b0);
    chk("R11 collision clears ref", refOutstanding, 1'b0);
  endtask

  task automatic t_soft();
    launch();
    flush = 1;
    step();
    flush = 0;
    #1 chk("R6 kill before soft reset", killResp, 1'b1);
    softReset = 1;
    #1 chk("R9 soft reset blocks", fetchReq, 1'b0);
    step();
    softReset = 0;
    #1 chk("R9 soft reset clears ref", refOutstanding, 1'b0);
    chk("R9 soft reset clears kill", killResp, 1'b0);
  endtask

  initial begin
    t_reset();
    t_room();
    t_normal();
    t_kill();
    t_collide();
    t_soft();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule